// File: doc/BRIEF.md
# Local Interrupt Timer with Power-of-Two Divider

This block is the timer slice of a local interrupt controller. A down-counter is loaded from an initial-count register and decremented once every N bus-clock cycles, where N is a power of two chosen by a divide-configuration register. When the count runs out, the block adds one to a pending counter. Depending on the periodic bit of its vector-table entry, the timer then either reloads and keeps running or stops. While interrupts are enabled and the entry is unmasked, a request with the entry's vector is held up as long as anything is pending. Each acceptance of that request removes one pending event.

The block also holds the controller's software-enable register and all six local vector-table entries, because disabling the controller has to mask every entry at once. Software uses a single-cycle write port and a combinational read port, both addressed by a small register index. The bus clock is the block clock.

Register index map (32-bit data): 0 control (bits 9:0 stored, bit 8 is software enable, reset 0x0FF), 1 timer entry, 2 thermal entry, 3 performance entry, 4 local-input-0 entry, 5 local-input-1 entry, 6 error entry, 7 initial count, 8 current count (read-only), 9 divide configuration (bits 3:0 stored), 10 pending count (read-only). All other indices read zero. In every entry, bits 7:0 hold the vector and bit 16 is the mask. Bit 17 of the timer entry selects periodic mode.

Top module: `lvt_timer`

## Requirements
- R1: The divide shift is formed from divide-configuration bits {3,1,0} as a 3-bit value plus one, wrapping modulo 8. The count steps once every 2^shift cycles, so 0000 divides by 2, 1011 divides by 1, 0011 by 16 and 1010 by 128.
- R2: Writing index 7 loads the current count with the written value, restarts the prescaler using the divisor configured at that moment, and clears the pending count in the same cycle.
- R3: With an initial count of zero the timer is stopped: index 8 reads zero and the pending count never increases.
- R4: After an initial-count write of N with divisor D, index 8 reads N - floor(k/D) k cycles later, for k below N*D.
- R5: Expiry happens N*D cycles after the count starts and adds one to the pending count. With timer-entry bit 17 set, the count reloads N and keeps running. With bit 17 clear, it reads zero and stops.
- R6: irq_req is high only when hw_en is high, control bit 8 is set, timer-entry bit 16 is clear and the pending count is non-zero. irq_vec carries timer-entry bits 7:0.
- R7: A cycle with irq_req and irq_ack both high lowers the pending count by one, unless an expiry lands in the same cycle, in which case the count holds.
- R8: Writing index 0 with bit 8 clear sets bit 16 in all six entries and clears the pending count.
- R9: While control bit 8 is clear, any entry write stores bit 16 as one regardless of the written data.
- R10: Entries keep only their writable bits: timer 0x000310FF, thermal and performance 0x000117FF, both local inputs 0x0001F7FF, error 0x000110FF.
- R11: After reset all six entries read 0x00010000, control reads 0x0FF, and indices 7 to 10 read zero.
- R12: A divide-configuration write during a count leaves the running period at its old divisor. The new divisor applies from the next reload or restart.
- R13: The pending count saturates at its maximum (15 with the default width) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, also the timer time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Controller hardware enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register index for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Register index for reads |
| rd_data | output | 32 | Combinational read data |
| irq_req | output | 1 | Timer interrupt request |
| irq_vec | output | 8 | Vector of the timer entry |
| irq_ack | input | 1 | Request accepted this cycle |

## Verification
The count is started under four divide settings (by 1, 2, 16 and 128). The current count is sampled mid-period and the pending count is read exactly one cycle before and at the expected expiry, which exposes any off-by-one in the prescaler or in the decode of the non-contiguous configuration bits. One-shot and periodic runs separate stop from reload. A divide change in mid-period shows whether the new divisor leaks into a running count. Saturation, restart, zero count, acknowledge, and gating by hw_en, the mask and software disable are each driven on their own, so that each condition alone can be seen to block or clear the request.

// File: rtl/lvt_timer.sv
module lvt_timer #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          irq_req,
  output logic [7:0]    irq_vec,
  input  logic          irq_ack
);
  localparam int N_LVT  = 6;
  localparam int A_CTL  = 0;
  localparam int A_LVT  = 1;
  localparam int A_INIT = 7;
  localparam int A_CUR  = 8;
  localparam int A_DIV  = 9;
  localparam int A_PEND = 10;
  localparam logic [31:0] MASKV = 32'h0001_0000;
  localparam logic [N_LVT-1:0][31:0] WM = {
    32'h0001_10FF, 32'h0001_F7FF, 32'h0001_F7FF,
    32'h0001_17FF, 32'h0001_17FF, 32'h0003_10FF};
  localparam logic [PEND_W-1:0] PMAX = '1;

  logic [9:0]             ctl_q;
  logic [N_LVT-1:0][31:0] lvt_q;
  logic [CNT_W-1:0]       init_q, cur_q;
  logic [3:0]             div_q;
  logic [2:0]             sh_q;
  logic [6:0]             pre_q;
  logic [PEND_W-1:0]      pend_q;

  wire       sw_en   = ctl_q[8];
  wire       init_wr = wr_en && wr_addr == AW'(A_INIT);
  wire       dis_wr  = wr_en && wr_addr == AW'(A_CTL) && !wr_data[8];
  wire [2:0] sh_new  = {div_q[3], div_q[1:0]} + 3'd1;
  wire [7:0] lim     = (8'd1 << sh_q) - 8'd1;
  wire       tick    = (cur_q != '0) && ({1'b0, pre_q} == lim);
  wire       fire    = tick && (cur_q == CNT_W'(1));
  wire       acc     = irq_req && irq_ack;

  assign irq_req = hw_en && sw_en && !lvt_q[0][16] && (pend_q != '0);
  assign irq_vec = lvt_q[0][7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_q <= 10'h0FF;
      div_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTL)) ctl_q <= wr_data[9:0];
      if (wr_addr == AW'(A_DIV)) div_q <= wr_data[3:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < N_LVT; i++) lvt_q[i] <= MASKV;
    end else begin
      for (int i = 0; i < N_LVT; i++)
        if (dis_wr)
          lvt_q[i] <= lvt_q[i] | MASKV;
        else if (wr_en && wr_addr == AW'(A_LVT + i))
          lvt_q[i] <= (wr_data & WM[i]) | (sw_en ? 32'h0 : MASKV);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      init_q <= '0;
      cur_q  <= '0;
      pre_q  <= '0;
      sh_q   <= 3'd1;
    end else if (init_wr) begin
      init_q <= wr_data[CNT_W-1:0];
      cur_q  <= wr_data[CNT_W-1:0];
      pre_q  <= '0;
      sh_q   <= sh_new;
    end else if (tick) begin
      pre_q <= '0;
      if (!fire)
        cur_q <= cur_q - CNT_W'(1);
      else if (lvt_q[0][17]) begin
        cur_q <= init_q;
        sh_q  <= sh_new;
      end else
        cur_q <= '0;
    end else if (cur_q != '0)
      pre_q <= pre_q + 7'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      pend_q <= '0;
    else if (init_wr || dis_wr)
      pend_q <= '0;
    else if (fire && !acc && pend_q != PMAX)
      pend_q <= pend_q + PEND_W'(1);
    else if (acc && !fire)
      pend_q <= pend_q - PEND_W'(1);

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_CTL))  rd_data = {22'h0, ctl_q};
    if (rd_addr == AW'(A_INIT)) rd_data = 32'(init_q);
    if (rd_addr == AW'(A_CUR))  rd_data = 32'(cur_q);
    if (rd_addr == AW'(A_DIV))  rd_data = {28'h0, div_q};
    if (rd_addr == AW'(A_PEND)) rd_data = 32'(pend_q);
    for (int i = 0; i < N_LVT; i++)
      if (rd_addr == AW'(A_LVT + i)) rd_data = lvt_q[i];
  end
endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4,
  parameter int AW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_en,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [31:0]       wr_data,
  input logic              irq_req,
  input logic              irq_ack,
  input logic              sw_en,
  input logic              tmask,
  input logic              per,
  input logic              fire,
  input logic [PEND_W-1:0] pend,
  input logic [CNT_W-1:0]  cur,
  input logic [CNT_W-1:0]  init
);
  a_r6_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (hw_en && sw_en && !tmask && pend != '0));

  a_r2_init_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(7)) |=> (pend == '0 && cur == $past(wr_data[CNT_W-1:0])));

  a_r7_ack_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !fire && !wr_en) |=> pend == $past(pend) - PEND_W'(1));

  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(0) && !wr_data[8]) |=> (pend == '0 && tmask));

  a_r4_cur_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cur <= init);

  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !per && !wr_en) |=> cur == '0);
endmodule

bind lvt_timer lvt_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq_req(irq_req), .irq_ack(irq_ack), .sw_en(sw_en),
  .tmask(lvt_q[0][16]), .per(lvt_q[0][17]), .fire(fire), .pend(pend_q),
  .cur(cur_q), .init(init_q));

// File: tb/lvt_timer_tb_top.sv
module lvt_timer_tb_top;
  typedef struct {
    bit          irq;
    logic [3:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0, hw_en = 1, wr_en = 0, irq_ack = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq_req;
  logic [7:0] irq_vec;
  int cyc = 0, w = 0, n_chk = 0, n_err = 0;
  int m_n = 0, m_d = 1;
  bit m_per = 0, done = 0;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lvt_timer dut_i (.clk(clk), .rst_n(rst_n), .hw_en(hw_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack));

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.irq ? {23'h0, irq_req, irq_vec} : rd_data;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
      end
    end
  end

  function automatic int cur_exp(int el);
    if (m_n == 0) return 0;
    if (!m_per) return (el >= m_n * m_d) ? 0 : m_n - el / m_d;
    return m_n - (el % (m_n * m_d)) / m_d;
  endfunction

  function automatic int pend_exp(int el);
    int p;
    if (m_n == 0) return 0;
    p = el / (m_n * m_d);
    if (!m_per && p > 1) p = 1;
    return (p > 15) ? 15 : p;
  endfunction

  task automatic chk_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    rd_addr = a;
    q.push_back('{irq: 0, a: a, exp: e, tag: tag});
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic [8:0] e, input string tag);
    q.push_back('{irq: 1, a: 0, exp: {23'h0, e}, tag: tag});
    @(negedge clk);
  endtask

  task automatic chk_cur(input string tag);
    chk_rd(4'd8, 32'(cur_exp(cyc - w)), tag);
  endtask

  task automatic chk_pend(input string tag);
    chk_rd(4'd10, 32'(pend_exp(cyc - w)), tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 4'd7) w = cyc;
  endtask

  task automatic start(input int n, input int d, input bit per);
    m_n = n; m_d = d; m_per = per;
    wr(4'd7, 32'(n));
  endtask

  task automatic wait_el(input int e);
    while (cyc - w < e) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 1; i <= 6; i++) chk_rd(4'(i), 32'h0001_0000, "R11 entry masked");
    chk_rd(4'd0, 32'h0FF, "R11 control");
    for (int i = 7; i <= 10; i++) chk_rd(4'(i), 0, "R11 timer regs zero");
    chk_irq(9'h000, "R11 no request");

    wr(4'd0, 32'h1FF);
    wr(4'd1, 32'h40);
    wr(4'd9, 32'hB);
    start(5, 1, 0);
    chk_cur("R4 div1 el0"); chk_cur("R4 div1 el1"); chk_cur("R4 div1 el2");
    wait_el(4); chk_pend("R5 one-shot before expiry");
    chk_pend("R5 one-shot expiry");
    chk_cur("R5 one-shot stopped");
    chk_irq(9'h140, "R6 request with vector");
    wait_el(20); chk_pend("R5 one-shot fires once");
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk_rd(4'd10, 0, "R7 ack decrements");
    chk_irq(9'h040, "R7 request drops");

    wr(4'd9, 32'h0);
    start(3, 2, 0);
    chk_cur("R1 div2 el0"); chk_cur("R1 div2 el1"); chk_cur("R1 div2 el2"); chk_cur("R1 div2 el3");
    wait_el(5); chk_pend("R1 div2 before"); chk_pend("R1 div2 expiry");
    wr(4'd9, 32'h3);
    start(3, 16, 0);
    wait_el(17); chk_cur("R1 div16 mid");
    wait_el(47); chk_pend("R1 div16 before"); chk_pend("R1 div16 expiry");
    wr(4'd9, 32'hA);
    start(2, 128, 0);
    wait_el(130); chk_cur("R1 div128 mid");
    wait_el(255); chk_pend("R1 div128 before"); chk_pend("R1 div128 expiry");

    wr(4'd1, 32'h20041);
    wr(4'd9, 32'hB);
    start(4, 1, 1);
    wait_el(12); chk_pend("R5 periodic three expiries");
    chk_cur("R5 periodic reloaded");
    chk_irq(9'h141, "R6 periodic vector");
    start(10, 1, 1);
    chk_rd(4'd10, 0, "R2 restart clears pending");
    chk_rd(4'd8, 32'd9, "R2 restart loads new count");

    start(4, 1, 1);
    wr(4'd9, 32'h0);
    wait_el(3); chk_cur("R12 old divisor kept");
    wait_el(6); chk_rd(4'd8, 32'd3, "R12 new divisor after reload");
    wait_el(11); chk_rd(4'd10, 1, "R12 second period not yet done");
    chk_rd(4'd10, 2, "R12 second period at 8 cycles");

    wr(4'd9, 32'hB);
    start(1, 1, 1);
    wait_el(30); chk_pend("R13 saturates at 15");
    hw_en = 0; chk_irq(9'h041, "R6 hw_en low blocks");
    hw_en = 1;
    wr(4'd1, 32'h30041); chk_irq(9'h041, "R6 mask blocks");
    wr(4'd1, 32'h20041); chk_irq(9'h141, "R6 unmasked again");

    start(0, 1, 0);
    chk_rd(4'd8, 0, "R3 zero count reads zero");
    wait_el(20);
    chk_rd(4'd8, 0, "R3 still stopped");
    chk_rd(4'd10, 0, "R3 no expiry");

    start(3, 1, 1);
    wait_el(7);
    wr(4'd0, 32'h0FF);
    chk_rd(4'd10, 0, "R8 pending cleared");
    chk_rd(4'd1, 32'h30041, "R8 timer masked");
    for (int i = 2; i <= 6; i++) chk_rd(4'(i), 32'h0001_0000, "R8 entry masked");
    chk_irq(9'h041, "R8 no request when disabled");
    start(0, 1, 0);
    wr(4'd2, 32'h123); chk_rd(4'd2, 32'h10123, "R9 thermal forced mask");
    wr(4'd1, 32'h42);  chk_rd(4'd1, 32'h10042, "R9 timer forced mask");

    wr(4'd0, 32'hFFFF_FE00);
    chk_rd(4'd0, 32'h200, "R10 control keeps bits 9:0");
    wr(4'd0, 32'h100);
    for (int i = 1; i <= 6; i++) wr(4'(i), 32'hFFFF_FFFF);
    chk_rd(4'd1, 32'h0003_10FF, "R10 timer writable bits");
    chk_rd(4'd2, 32'h0001_17FF, "R10 thermal writable bits");
    chk_rd(4'd3, 32'h0001_17FF, "R10 perf writable bits");
    chk_rd(4'd4, 32'h0001_F7FF, "R10 input0 writable bits");
    chk_rd(4'd5, 32'h0001_F7FF, "R10 input1 writable bits");
    chk_rd(4'd6, 32'h0001_10FF, "R10 error writable bits");
    wr(4'd9, 32'hFFFF_FFFF);
    chk_rd(4'd9, 32'hF, "R1 divide register width");

    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule